// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block holds a device's lifecycle state and the count of transition attempts it has made. It takes a start strobe together with a target state, a token and two request bits. It checks the request against a fixed table of legal successors and compares the token. It then reports the result on a set of status flags. Storage that keeps its contents without power is outside the block. When a regular attempt ends, the block gives the values to be programmed (state and count) on a one-cycle write port. At reset it loads the stored values back through its initial-value inputs.

Every regular attempt consumes one count value and parks the controller in a post-transition code, whether the attempt succeeds or fails. After that, only a reset reopens the command path. A build-time option adds a volatile unlock from the blank state to the first unlocked test state. It compares the token against a pre-hashed constant, spends no count value, and leaves the controller ready for another command. A request for the external clock is passed on only in states where the clock source may be switched.

Top module: `lcx_seq`

## Requirements
- R1: On reset the state loads from `init_state` and the count from `init_count`, with all status flags clear. `st_ready` is 1 exactly when the state code is 0..12 and no command is in flight or finished. The codes are: 0 blank, 1..4 test-unlocked 0..3, 5..7 test-locked 0..2, 8 development, 9 production, 10 production-end, 11 return-to-vendor, 12 scrapped, 13 post-transition, 14..15 invalid.
- R2: A `start` sampled high while `st_ready` is 1 captures the request. The result appears on the outputs after the second rising edge counted from that edge. A `start` seen while `st_ready` is 0 is dropped.
- R3: A regular attempt adds one to the count and moves the state to code 13. It pulses `prog_valid` for one cycle. `prog_count` carries the new count. `prog_state` carries the target on success and the old state on failure.
- R4: After a regular attempt, or after any error, `st_ready` stays 0 and state, count and status hold until reset.
- R5: The legal successors are as follows. Every state 0..11 may go to 12. Code 0 may go to 1. Test-unlocked n may go to test-locked m when m ≥ n, and to 8, 9, 10 or 11. Test-locked n may go to test-unlocked m when m > n, and to 8, 9 or 10. Codes 8 and 9 may go to 11. Code 12 has no successor.
- R6: Moves to a test-unlocked state need `TOK_UNLOCK`. Moves to 8..10 need `TOK_EXIT`. Moves to 11 need `TOK_RMA`. All other legal moves need an all-zero token. A mismatch sets `st_token_err` and still counts as an attempt.
- R7: A target that is not a legal successor sets `st_trans_err`, whatever the token, and still counts as an attempt.
- R8: With the count at `CNT_MAX` (24), a regular start sets `st_count_err`. State and count stay unchanged and `prog_valid` stays 0.
- R9: `ext_clk_en` follows `ext_clk_req` when the state is 0..7 or 11, and is 0 in every other state.
- R10: With `VOL_EN`=1, a request with `vol_unlock_req`=1, state 0 and target 1 compares the token with `TOK_VOL`. On a match the state becomes 1, `st_success` sets, the count stays, no `prog_valid` pulse is given, and `st_ready` returns to 1. On a mismatch `st_token_err` sets and the count stays. This path is taken even at the maximum count.
- R11: `vol_unlock_rb` equals `vol_unlock_req` when `VOL_EN`=1 and is 0 otherwise. With `VOL_EN`=0 the volatile request is ignored and the command runs as a regular attempt.
- R12: `st_success` clears on the edge that accepts a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads the initial values |
| init_state | input | 4 | Stored state loaded at reset |
| init_count | input | CNTW | Stored attempt count loaded at reset |
| start | input | 1 | Command strobe |
| tgt_state | input | 4 | Requested target state |
| token | input | TOKW | Supplied token |
| ext_clk_req | input | 1 | Request to run from the external clock |
| vol_unlock_req | input | 1 | Request for the volatile unlock path |
| st_ready | output | 1 | Ready for a command |
| st_success | output | 1 | Last command succeeded |
| st_count_err | output | 1 | Attempt counter exhausted |
| st_trans_err | output | 1 | Target not a legal successor |
| st_token_err | output | 1 | Token mismatch |
| cur_state | output | 4 | Current state code |
| cur_count | output | CNTW | Current attempt count |
| ext_clk_en | output | 1 | Gated external-clock enable |
| vol_unlock_rb | output | 1 | Read-back of the volatile request bit |
| prog_valid | output | 1 | One-cycle write strobe for storage |
| prog_state | output | 4 | State to be stored |
| prog_count | output | CNTW | Count to be stored |

## Verification
The bench builds the block twice, each with an 8-bit token and the default counter limit of 24. One instance has the volatile path enabled and the other has it disabled. The narrow token keeps the pass and fail token values easy to compute. With 16 state codes, the bench can sweep every current-state and target pair, under a correct, an all-zero and a wrong token, from a fresh reset. Reset preloading puts the count-limit corners and the volatile path within a few cycles of each other, on both builds.

// File: rtl/lcx_pkg.sv
package lcx_pkg;

    typedef enum logic [3:0] {
        LC_RAW   = 4'd0,
        LC_TU0   = 4'd1,
        LC_TU1   = 4'd2,
        LC_TU2   = 4'd3,
        LC_TU3   = 4'd4,
        LC_TL0   = 4'd5,
        LC_TL1   = 4'd6,
        LC_TL2   = 4'd7,
        LC_DEV   = 4'd8,
        LC_PROD  = 4'd9,
        LC_PEND  = 4'd10,
        LC_RMA   = 4'd11,
        LC_SCRAP = 4'd12,
        LC_POST  = 4'd13,
        LC_INV   = 4'd14,
        LC_RSVD  = 4'd15
    } lc_state_e;

    typedef enum logic [1:0] {
        TC_ZERO   = 2'd0,
        TC_UNLOCK = 2'd1,
        TC_EXIT   = 2'd2,
        TC_RMA    = 2'd3
    } tok_class_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_EVAL = 2'd1,
        SQ_HALT = 2'd2
    } seq_e;

    typedef struct packed {
        logic       legal;
        tok_class_e cls;
    } rule_t;

    typedef struct packed {
        logic success;
        logic count_err;
        logic trans_err;
        logic token_err;
    } lc_status_t;

    function automatic logic in_range(logic [3:0] v, logic [3:0] lo, logic [3:0] hi);
        return (v >= lo) && (v <= hi);
    endfunction

    // States from which commands may be issued at all
    function automatic logic lc_operable(lc_state_e s);
        return 4'(s) <= 4'(LC_SCRAP);
    endfunction

    // External clock may be switched in blank, test and return states
    function automatic logic lc_ext_clk_ok(lc_state_e s);
        return (4'(s) <= 4'(LC_TL2)) || (s == LC_RMA);
    endfunction

    function automatic rule_t lc_rule(lc_state_e cur, lc_state_e tgt);
        rule_t      r;
        logic [3:0] c;
        logic [3:0] t;
        c = 4'(cur);
        t = 4'(tgt);
        r.legal = 1'b0;
        r.cls   = TC_ZERO;
        if (tgt == LC_SCRAP && c <= 4'(LC_RMA)) begin
            r.legal = 1'b1;
        end else if (c == 4'(LC_RAW)) begin
            if (tgt == LC_TU0) begin
                r.legal = 1'b1;
                r.cls   = TC_UNLOCK;
            end
        end else if (in_range(c, 4'(LC_TU0), 4'(LC_TU3))) begin
            if (in_range(t, 4'(LC_TL0), 4'(LC_TL2)) && ((t - 4'd5) >= (c - 4'd1))) begin
                r.legal = 1'b1;
            end else if (in_range(t, 4'(LC_DEV), 4'(LC_PEND))) begin
                r.legal = 1'b1;
                r.cls   = TC_EXIT;
            end else if (tgt == LC_RMA) begin
                r.legal = 1'b1;
                r.cls   = TC_RMA;
            end
        end else if (in_range(c, 4'(LC_TL0), 4'(LC_TL2))) begin
            if (in_range(t, 4'(LC_TU0), 4'(LC_TU3)) && ((t - 4'd1) > (c - 4'd5))) begin
                r.legal = 1'b1;
                r.cls   = TC_UNLOCK;
            end else if (in_range(t, 4'(LC_DEV), 4'(LC_PEND))) begin
                r.legal = 1'b1;
                r.cls   = TC_EXIT;
            end
        end else if (cur == LC_DEV || cur == LC_PROD) begin
            if (tgt == LC_RMA) begin
                r.legal = 1'b1;
                r.cls   = TC_RMA;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/lcx_rules.sv
module lcx_rules
    import lcx_pkg::*;
(
    input  lc_state_e cur,
    input  lc_state_e tgt,
    output rule_t     rule
);
    assign rule = lc_rule(cur, tgt);
endmodule

// File: rtl/lcx_token_chk.sv
module lcx_token_chk
    import lcx_pkg::*;
#(
    parameter int              TOKW       = 16,
    parameter logic [TOKW-1:0] TOK_UNLOCK = '1,
    parameter logic [TOKW-1:0] TOK_EXIT   = '1,
    parameter logic [TOKW-1:0] TOK_RMA    = '1,
    parameter logic [TOKW-1:0] TOK_VOL    = '1
) (
    input  tok_class_e      cls,
    input  logic            vol_path,
    input  logic [TOKW-1:0] token,
    output logic            tok_ok
);
    logic [TOKW-1:0] expect_tok;

    always_comb begin
        if (vol_path) begin
            expect_tok = TOK_VOL;
        end else begin
            unique case (cls)
                TC_UNLOCK: expect_tok = TOK_UNLOCK;
                TC_EXIT:   expect_tok = TOK_EXIT;
                TC_RMA:    expect_tok = TOK_RMA;
                default:   expect_tok = '0;
            endcase
        end
    end

    assign tok_ok = (token == expect_tok);
endmodule

// File: rtl/lcx_core.sv
module lcx_core
    import lcx_pkg::*;
#(
    parameter int TOKW    = 16,
    parameter int CNT_MAX = 24,
    parameter int CNTW    = 5,
    parameter bit VOL_EN  = 1'b1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      init_state,
    input  logic [CNTW-1:0] init_count,
    input  logic            start,
    input  logic [3:0]      tgt_in,
    input  logic [TOKW-1:0] tok_in,
    input  logic            vol_in,
    input  rule_t           rule,
    input  logic            tok_ok,
    output lc_state_e       cur_q,
    output lc_state_e       tgt_q,
    output logic [TOKW-1:0] tok_q,
    output logic            vol_path,
    output logic [CNTW-1:0] cnt_q,
    output lc_status_t      stat_q,
    output logic            rdy,
    output logic            pv_q,
    output lc_state_e       pst_q,
    output logic [CNTW-1:0] pcnt_q
);
    localparam logic [CNTW-1:0] CMAX = CNTW'(CNT_MAX);

    seq_e seq_q;
    logic vol_q;

    assign rdy = (seq_q == SQ_IDLE) && lc_operable(cur_q);

    generate
        if (VOL_EN) begin : g_vol
            assign vol_path = vol_q && (cur_q == LC_RAW) && (tgt_q == LC_TU0);
        end else begin : g_novol
            assign vol_path = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= lc_state_e'(init_state);
            cnt_q  <= init_count;
            seq_q  <= SQ_IDLE;
            stat_q <= '0;
            tgt_q  <= LC_RAW;
            tok_q  <= '0;
            vol_q  <= 1'b0;
            pv_q   <= 1'b0;
            pst_q  <= LC_RAW;
            pcnt_q <= '0;
        end else begin
            pv_q <= 1'b0;
            unique case (seq_q)
                SQ_IDLE: begin
                    if (start && rdy) begin
                        tgt_q          <= lc_state_e'(tgt_in);
                        tok_q          <= tok_in;
                        vol_q          <= vol_in && VOL_EN;
                        stat_q.success <= 1'b0;
                        seq_q          <= SQ_EVAL;
                    end
                end
                SQ_EVAL: begin
                    if (vol_path) begin
                        if (tok_ok) begin
                            cur_q          <= LC_TU0;
                            stat_q.success <= 1'b1;
                            seq_q          <= SQ_IDLE;
                        end else begin
                            stat_q.token_err <= 1'b1;
                            seq_q            <= SQ_HALT;
                        end
                    end else if (cnt_q >= CMAX) begin
                        stat_q.count_err <= 1'b1;
                        seq_q            <= SQ_HALT;
                    end else begin
                        cnt_q  <= cnt_q + CNTW'(1);
                        pcnt_q <= cnt_q + CNTW'(1);
                        cur_q  <= LC_POST;
                        pv_q   <= 1'b1;
                        pst_q  <= (rule.legal && tok_ok) ? tgt_q : cur_q;
                        if (!rule.legal) begin
                            stat_q.trans_err <= 1'b1;
                        end else if (!tok_ok) begin
                            stat_q.token_err <= 1'b1;
                        end else begin
                            stat_q.success <= 1'b1;
                        end
                        seq_q <= SQ_HALT;
                    end
                end
                default: ;
            endcase
        end
    end

    // R1
    ready_clean_chk: assert property (@(posedge clk) disable iff (rst)
        rdy |-> !(stat_q.count_err || stat_q.trans_err || stat_q.token_err));

    // R4
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q == SQ_HALT) |=> (seq_q == SQ_HALT) && $stable(cur_q) && $stable(cnt_q));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + CNTW'(1)));

    // R3
    post_chk: assert property (@(posedge clk) disable iff (rst)
        pv_q |-> (cur_q == LC_POST) && (cnt_q == pcnt_q));

    // R8
    cnt_max_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q == SQ_EVAL && !vol_path && cnt_q == CMAX)
            |=> stat_q.count_err && $stable(cur_q) && !pv_q);

    // R10
    vol_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_q == SQ_EVAL && vol_path) |=> $stable(cnt_q) && !pv_q);

    // R7
    err_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stat_q.count_err, stat_q.trans_err, stat_q.token_err}));

endmodule

// File: rtl/lcx_seq.sv
module lcx_seq
    import lcx_pkg::*;
#(
    parameter int              TOKW       = 16,
    parameter int              CNT_MAX    = 24,
    parameter bit              VOL_EN     = 1'b1,
    parameter logic [TOKW-1:0] TOK_UNLOCK = TOKW'(16'hA5C3),
    parameter logic [TOKW-1:0] TOK_EXIT   = TOKW'(16'h3C96),
    parameter logic [TOKW-1:0] TOK_RMA    = TOKW'(16'h7711),
    parameter logic [TOKW-1:0] TOK_VOL    = TOKW'(16'h5AE2),
    localparam int             CNTW       = $clog2(CNT_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [3:0]      init_state,
    input  logic [CNTW-1:0] init_count,
    input  logic            start,
    input  logic [3:0]      tgt_state,
    input  logic [TOKW-1:0] token,
    input  logic            ext_clk_req,
    input  logic            vol_unlock_req,
    output logic            st_ready,
    output logic            st_success,
    output logic            st_count_err,
    output logic            st_trans_err,
    output logic            st_token_err,
    output logic [3:0]      cur_state,
    output logic [CNTW-1:0] cur_count,
    output logic            ext_clk_en,
    output logic            vol_unlock_rb,
    output logic            prog_valid,
    output logic [3:0]      prog_state,
    output logic [CNTW-1:0] prog_count
);
    lc_state_e       cur_q, tgt_q, pst_q;
    logic [TOKW-1:0] tok_q;
    logic            vol_path, tok_ok, rdy, pv_q;
    logic [CNTW-1:0] cnt_q, pcnt_q;
    lc_status_t      stat_q;
    rule_t           rule;

    lcx_rules u_rules (
        .cur  (cur_q),
        .tgt  (tgt_q),
        .rule (rule)
    );

    lcx_token_chk #(
        .TOKW       (TOKW),
        .TOK_UNLOCK (TOK_UNLOCK),
        .TOK_EXIT   (TOK_EXIT),
        .TOK_RMA    (TOK_RMA),
        .TOK_VOL    (TOK_VOL)
    ) u_tok (
        .cls      (rule.cls),
        .vol_path (vol_path),
        .token    (tok_q),
        .tok_ok   (tok_ok)
    );

    lcx_core #(
        .TOKW    (TOKW),
        .CNT_MAX (CNT_MAX),
        .CNTW    (CNTW),
        .VOL_EN  (VOL_EN)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .init_state (init_state),
        .init_count (init_count),
        .start      (start),
        .tgt_in     (tgt_state),
        .tok_in     (token),
        .vol_in     (vol_unlock_req),
        .rule       (rule),
        .tok_ok     (tok_ok),
        .cur_q      (cur_q),
        .tgt_q      (tgt_q),
        .tok_q      (tok_q),
        .vol_path   (vol_path),
        .cnt_q      (cnt_q),
        .stat_q     (stat_q),
        .rdy        (rdy),
        .pv_q       (pv_q),
        .pst_q      (pst_q),
        .pcnt_q     (pcnt_q)
    );

    generate
        if (VOL_EN) begin : g_rb
            assign vol_unlock_rb = vol_unlock_req;
        end else begin : g_rb_off
            assign vol_unlock_rb = 1'b0;
        end
    endgenerate

    assign st_ready     = rdy;
    assign st_success   = stat_q.success;
    assign st_count_err = stat_q.count_err;
    assign st_trans_err = stat_q.trans_err;
    assign st_token_err = stat_q.token_err;
    assign cur_state    = 4'(cur_q);
    assign cur_count    = cnt_q;
    assign ext_clk_en   = ext_clk_req && lc_ext_clk_ok(cur_q);
    assign prog_valid   = pv_q;
    assign prog_state   = 4'(pst_q);
    assign prog_count   = pcnt_q;

endmodule

// File: tb/tb_lcx_seq.sv
module tb_lcx_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TOKW = 8;
    localparam int CNTW = 5;
    localparam logic [7:0] T_UNL = 8'hA5;
    localparam logic [7:0] T_EXI = 8'h3C;
    localparam logic [7:0] T_RMA = 8'h77;
    localparam logic [7:0] T_VOL = 8'h5A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] init_state = '0;
    logic [CNTW-1:0] init_count = '0;
    logic start = 1'b0;
    logic [3:0] tgt_state = '0;
    logic [TOKW-1:0] token = '0;
    logic ext_clk_req = 1'b0;
    logic vol_unlock_req = 1'b0;

    logic rdy, suc, cerr, terr, kerr, eclk, vrb, pv;
    logic [3:0] cst, pst;
    logic [CNTW-1:0] ccnt, pcnt;
    logic n_rdy, n_suc, n_cerr, n_terr, n_kerr, n_eclk, n_vrb, n_pv;
    logic [3:0] n_cst, n_pst;
    logic [CNTW-1:0] n_ccnt, n_pcnt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcx_seq #(.TOKW(TOKW), .VOL_EN(1'b1), .TOK_UNLOCK(T_UNL), .TOK_EXIT(T_EXI),
              .TOK_RMA(T_RMA), .TOK_VOL(T_VOL)) dut (
        .clk(clk), .rst(rst), .init_state(init_state), .init_count(init_count),
        .start(start), .tgt_state(tgt_state), .token(token), .ext_clk_req(ext_clk_req),
        .vol_unlock_req(vol_unlock_req), .st_ready(rdy), .st_success(suc),
        .st_count_err(cerr), .st_trans_err(terr), .st_token_err(kerr),
        .cur_state(cst), .cur_count(ccnt), .ext_clk_en(eclk), .vol_unlock_rb(vrb),
        .prog_valid(pv), .prog_state(pst), .prog_count(pcnt));

    lcx_seq #(.TOKW(TOKW), .VOL_EN(1'b0), .TOK_UNLOCK(T_UNL), .TOK_EXIT(T_EXI),
              .TOK_RMA(T_RMA), .TOK_VOL(T_VOL)) dut_nv (
        .clk(clk), .rst(rst), .init_state(init_state), .init_count(init_count),
        .start(start), .tgt_state(tgt_state), .token(token), .ext_clk_req(ext_clk_req),
        .vol_unlock_req(vol_unlock_req), .st_ready(n_rdy), .st_success(n_suc),
        .st_count_err(n_cerr), .st_trans_err(n_terr), .st_token_err(n_kerr),
        .cur_state(n_cst), .cur_count(n_ccnt), .ext_clk_en(n_eclk), .vol_unlock_rb(n_vrb),
        .prog_valid(n_pv), .prog_state(n_pst), .prog_count(n_pcnt));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Token class per the legal-successor table: -1 illegal, 0 zero, 1 unlock, 2 exit, 3 rma
    function automatic int ref_class(int c, int t);
        if (c <= 11 && t == 12) return 0;
        if (c == 0) return (t == 1) ? 1 : -1;
        if (c >= 1 && c <= 4) begin
            if (t >= 5 && t <= 7 && (t - 5) >= (c - 1)) return 0;
            if (t >= 8 && t <= 10) return 2;
            if (t == 11) return 3;
            return -1;
        end
        if (c >= 5 && c <= 7) begin
            if (t >= 1 && t <= 4 && (t - 1) > (c - 5)) return 1;
            if (t >= 8 && t <= 10) return 2;
            return -1;
        end
        if ((c == 8 || c == 9) && t == 11) return 3;
        return -1;
    endfunction

    function automatic logic [7:0] class_tok(int k);
        case (k)
            1: return T_UNL;
            2: return T_EXI;
            3: return T_RMA;
            default: return 8'h00;
        endcase
    endfunction

    task automatic do_reset(input int s, input int c);
        @(negedge clk);
        rst = 1'b1;
        init_state = 4'(s);
        init_count = CNTW'(c);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
    endtask

    // start sampled at edge k, outcome visible after edge k+1
    task automatic run_cmd(input int t, input logic [7:0] tk, input bit v);
        @(negedge clk);
        tgt_state = 4'(t);
        token = tk;
        vol_unlock_req = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        // Full sweep: every current state x target x token pattern
        for (int c = 0; c < 16; c++) begin
            for (int t = 0; t < 16; t++) begin
                for (int p = 0; p < 3; p++) begin
                    int k;
                    logic [7:0] tk;
                    bit ok;
                    ext_clk_req = 1'b1;
                    vol_unlock_req = 1'b0;
                    do_reset(c, 3);
                    chk("R1 ready after reset", rdy, (c <= 12) ? 1 : 0);
                    chk("R1 state load", cst, c);
                    chk("R1 status clear", {suc, cerr, terr, kerr}, 0);
                    chk("R9 ext clk gate", eclk, (c <= 7 || c == 11) ? 1 : 0);
                    k = ref_class(c, t);
                    tk = (p == 0) ? class_tok(k < 0 ? 0 : k) : (p == 1) ? 8'h00 : 8'hFF;
                    run_cmd(t, tk, 1'b0);
                    if (c > 12) begin
                        chk("R2 start ignored state", cst, c);
                        chk("R2 start ignored count", ccnt, 3);
                        chk("R2 start ignored status", {suc, cerr, terr, kerr, pv}, 0);
                    end else begin
                        ok = (k >= 0) && (tk == class_tok(k));
                        chk("R3 post state", cst, 13);
                        chk("R3 count step", ccnt, 4);
                        chk("R3 prog pulse", pv, 1);
                        chk("R3 prog count", pcnt, 4);
                        chk("R3 prog state", pst, ok ? t : c);
                        chk("R5 success", suc, ok ? 1 : 0);
                        chk("R7 trans err", terr, (k < 0) ? 1 : 0);
                        chk("R6 token err", kerr, (k >= 0 && !ok) ? 1 : 0);
                        chk("R4 not ready", rdy, 0);
                        chk("R9 ext clk in post", eclk, 0);
                        @(negedge clk);
                        #1;
                        chk("R3 prog pulse ends", pv, 0);
                    end
                end
            end
        end
        ext_clk_req = 1'b0;

        // R4: second command after an attempt is dropped
        do_reset(1, 7);
        run_cmd(5, 8'h00, 1'b0);
        run_cmd(6, 8'h00, 1'b0);
        chk("R4 state held", cst, 13);
        chk("R4 count held", ccnt, 8);
        chk("R4 no new pulse", pv, 0);
        chk("R4 success held", suc, 1);

        // R8: counter exhausted
        do_reset(1, 24);
        run_cmd(5, 8'h00, 1'b0);
        chk("R8 count err", cerr, 1);
        chk("R8 state kept", cst, 1);
        chk("R8 count kept", ccnt, 24);
        chk("R8 no pulse", pv, 0);
        chk("R8 not ready", rdy, 0);
        do_reset(1, 23);
        run_cmd(5, 8'h00, 1'b0);
        chk("R8 last value usable", ccnt, 24);
        chk("R8 last value state", cst, 13);
        chk("R8 last value no err", cerr, 0);

        // R10 / R11: volatile unlock on both builds
        do_reset(0, 5);
        vol_unlock_req = 1'b1;
        #1;
        chk("R11 readback enabled", vrb, 1);
        chk("R11 readback tied off", n_vrb, 0);
        run_cmd(1, T_VOL, 1'b1);
        chk("R10 vol state", cst, 1);
        chk("R10 vol count kept", ccnt, 5);
        chk("R10 vol success", suc, 1);
        chk("R10 vol ready", rdy, 1);
        chk("R10 vol no pulse", pv, 0);
        chk("R11 regular path state", n_cst, 13);
        chk("R11 regular path count", n_ccnt, 6);
        chk("R11 regular path token err", n_kerr, 1);
        // R12: follow-up command clears success on accept
        @(negedge clk);
        vol_unlock_req = 1'b0;
        tgt_state = 4'd5;
        token = 8'h00;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R12 success cleared", suc, 0);
        chk("R12 busy", rdy, 0);
        @(negedge clk);
        #1;
        chk("R10 follow-up state", cst, 13);
        chk("R10 follow-up count", ccnt, 6);
        chk("R10 follow-up prog state", pst, 5);
        chk("R10 follow-up success", suc, 1);

        // R10: wrong volatile token
        do_reset(0, 5);
        run_cmd(1, 8'h11, 1'b1);
        chk("R10 vol token err", kerr, 1);
        chk("R10 vol bad state", cst, 0);
        chk("R10 vol bad count", ccnt, 5);
        chk("R10 vol bad not ready", rdy, 0);
        chk("R10 vol bad no pulse", pv, 0);

        // R10: volatile path at exhausted counter
        do_reset(0, 24);
        run_cmd(1, T_VOL, 1'b1);
        chk("R10 vol at max state", cst, 1);
        chk("R10 vol at max count err", cerr, 0);

        // R10: volatile bit outside blank state runs regular path
        do_reset(5, 2);
        run_cmd(2, T_UNL, 1'b1);
        chk("R10 non-blank regular state", cst, 13);
        chk("R10 non-blank regular prog", pst, 2);
        chk("R10 non-blank regular count", ccnt, 3);
        vol_unlock_req = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule